// File: doc/BRIEF.md
# Three-Segment Gamma Correction Engine

This block corrects the level of each of three colour channels on its way to the display. Every pixel level goes through a piecewise-linear curve stored in three tables. A 9-entry table serves the levels nearest black one step at a time. A 257-entry table covers the dark range in steps eight levels wide. A second 257-entry table covers the whole range in steps of 1024 levels. The block picks the table from the level itself, fetches the two neighbouring entries and interpolates between them. Levels at or above full scale take a separate per-channel full-scale value, which is wider than any table entry.

Software loads the tables through a small register port with a write strobe. An index register selects the table and the starting entry, and can set auto-increment. A data register takes each 16-bit entry as two words: the upper ten bits first, then the lower six. Pixels may stream while tables are rewritten. A pixel always sees the table contents that were in place before the write of the same cycle.

Top module: `gamma_mseg`

## Requirements
- R1: Pixel levels are 19-bit unsigned, and 262144 stands for 1.0. A level below 8 returns superfine entry `level` of its channel directly, with no interpolation.
- R2: A level from 8 to 2047 uses fine entries i = level>>3 and i+1 with weight w = level[2:0]. The output is e0 + ((e1-e0)*w)>>3, with the fraction truncated toward zero.
- R3: A level from 2048 to 262143 uses coarse entries i = level>>10 and i+1 with weight level[9:0]. The output is e0 + ((e1-e0)*w)>>10, truncated toward zero for rising and for falling curves. Entry 256 is the upper neighbour of entry 255.
- R4: A level of 262144 or more returns that channel's 17-bit full-scale register.
- R5: A data write (address 1) with no half-entry pending holds the upper bits: red from bits 29:20, green from 19:10, blue from 9:0. The next data write supplies the lower bits (red 29:24, green 19:14, blue 5:0) and commits the 16-bit entry. A write to the index register discards a pending half-entry.
- R6: If auto-increment is set, each committed entry advances the index, and the index wraps to 0 after the last entry of the selected table (8 for superfine, 256 otherwise). With the flag clear, the index stays put.
- R7: Index register (address 0): bits 8:0 give the entry, bits 10:9 the table (0 superfine, 1 fine, 2 coarse), and bit 15 auto-increment. Table code 3 discards committed entries. Addresses 2, 3 and 4 write bits 16:0 into the red, green and blue full-scale registers.
- R8: The result of a pixel appears two clock edges after it is presented, with `out_valid` high for exactly one cycle. After reset, `out_valid` and all outputs are 0.
- R9: A pixel presented in the same cycle as the commit of an entry it reads gets the previous entry value.
- R10: Outputs hold their values while no result is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_r | input | 19 | Red input level |
| pix_g | input | 19 | Green input level |
| pix_b | input | 19 | Blue input level |
| out_valid | output | 1 | Corrected pixel valid |
| out_r | output | 17 | Red corrected level |
| out_g | output | 17 | Green corrected level |
| out_b | output | 17 | Blue corrected level |

## Verification
A pixel driven before clock edge k is captured with its table reads at edge k, and its result is registered at edge k+1. The bench drives each pixel on a falling edge, drops the valid one falling edge later, and checks the three outputs and `out_valid` on the falling edge that follows. At that same middle falling edge it confirms that `out_valid` is still low. A register write lands at the rising edge after it is driven, so table changes are checked with a pixel presented one cycle later. For the same-cycle case, the committing write and the pixel share one edge and the old value is expected.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic [1:0] {
    SEG_SF   = 2'd0,
    SEG_FINE = 2'd1,
    SEG_CRS  = 2'd2,
    SEG_NONE = 2'd3
  } seg_e;

  localparam logic [2:0] A_INDEX = 3'd0;
  localparam logic [2:0] A_DATA  = 3'd1;
  localparam logic [2:0] A_FS0   = 3'd2;

  localparam int HI_W     = 10;
  localparam int LO_W     = 6;
  localparam int ENT_W    = HI_W + LO_W;
  localparam int IDX_LSB  = 0;
  localparam int SEG_LSB  = 9;
  localparam int AINC_BIT = 15;

  // channel 0 = red, 1 = green, 2 = blue
  localparam int HI_POS [3] = '{20, 10, 0};
  localparam int LO_POS [3] = '{24, 14, 0};
endpackage

// File: rtl/gamma_prog.sv
module gamma_prog
  import gamma_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int SF_N   = 9,
  parameter int FINE_N = 257,
  parameter int CRS_N  = 257,
  parameter int FS_W   = 17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [2:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic                        commit_o,
  output seg_e                        seg_o,
  output logic [IDX_W-1:0]            waddr_o,
  output logic                        ainc_o,
  output logic                        phase_o,
  output logic [2:0][ENT_W-1:0]       wval_o,
  output logic [2:0][FS_W-1:0]        fs_o
);
  logic [IDX_W-1:0]     idx_q, idx_d;
  seg_e                 seg_q, seg_d;
  logic                 ainc_q, ainc_d;
  logic                 phase_q, phase_d;
  logic [2:0][HI_W-1:0] hi_q, hi_d;
  logic [2:0][FS_W-1:0] fs_q, fs_d;
  logic                 is_idx, is_data, commit;
  logic [IDX_W-1:0]     last;
  logic                 unused_top;

  assign unused_top = ^cfg_wdata[31:30];
  assign is_idx  = cfg_we && (cfg_addr == A_INDEX);
  assign is_data = cfg_we && (cfg_addr == A_DATA);
  assign commit  = is_data && phase_q;

  always_comb begin
    case (seg_q)
      SEG_SF:   last = IDX_W'(SF_N - 1);
      SEG_FINE: last = IDX_W'(FINE_N - 1);
      default:  last = IDX_W'(CRS_N - 1);
    endcase
  end

  always_comb begin
    idx_d   = idx_q;
    seg_d   = seg_q;
    ainc_d  = ainc_q;
    phase_d = phase_q;
    hi_d    = hi_q;
    fs_d    = fs_q;
    if (is_idx) begin
      idx_d   = cfg_wdata[IDX_LSB +: IDX_W];
      seg_d   = seg_e'(cfg_wdata[SEG_LSB +: 2]);
      ainc_d  = cfg_wdata[AINC_BIT];
      phase_d = 1'b0;
    end else if (is_data) begin
      phase_d = ~phase_q;
      if (!phase_q) begin
        for (int c = 0; c < 3; c++) hi_d[c] = cfg_wdata[HI_POS[c] +: HI_W];
      end else if (ainc_q && (seg_q != SEG_NONE)) begin
        idx_d = (idx_q >= last) ? '0 : idx_q + 1'b1;
      end
    end
    for (int c = 0; c < 3; c++) begin
      if (cfg_we && (cfg_addr == A_FS0 + 3'(c))) fs_d[c] = cfg_wdata[FS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      seg_q   <= SEG_SF;
      ainc_q  <= 1'b0;
      phase_q <= 1'b0;
      hi_q    <= '0;
      fs_q    <= '0;
    end else if (cfg_we) begin
      idx_q   <= idx_d;
      seg_q   <= seg_d;
      ainc_q  <= ainc_d;
      phase_q <= phase_d;
      hi_q    <= hi_d;
      fs_q    <= fs_d;
    end
  end

  always_comb begin
    for (int c = 0; c < 3; c++) wval_o[c] = {hi_q[c], cfg_wdata[LO_POS[c] +: LO_W]};
  end

  assign commit_o = commit && (seg_q != SEG_NONE);
  assign seg_o    = seg_q;
  assign waddr_o  = idx_q;
  assign ainc_o   = ainc_q;
  assign phase_o  = phase_q;
  assign fs_o     = fs_q;
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int DEPTH = 257,
  parameter int W     = 16,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ra0,
  input  logic [IDX_W-1:0] ra1,
  output logic [W-1:0]     rd0,
  output logic [W-1:0]     rd1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rd0 = (int'(ra0) < DEPTH) ? mem[ra0] : '0;
  assign rd1 = (int'(ra1) < DEPTH) ? mem[ra1] : '0;
endmodule

// File: rtl/gamma_chan.sv
module gamma_chan
  import gamma_pkg::*;
#(
  parameter int LVL_W   = 19,
  parameter int IDX_W   = 9,
  parameter int SF_N    = 9,
  parameter int FINE_N  = 257,
  parameter int CRS_N   = 257,
  parameter int FINE_SH = 3,
  parameter int CRS_SH  = 10,
  parameter int FS_W    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             s1_valid,
  input  logic [LVL_W-1:0] level,
  input  logic             we_sf,
  input  logic             we_fine,
  input  logic             we_crs,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wval,
  input  logic [FS_W-1:0]  fs,
  output logic [FS_W-1:0]  out
);
  localparam int FULL     = 1 << (LVL_W - 1);
  localparam int SF_LIM   = SF_N - 1;
  localparam int FINE_LIM = (FINE_N - 1) << FINE_SH;
  localparam int FR_W     = CRS_SH;
  localparam int DIF_W    = FS_W + 1;
  localparam int PR_W     = DIF_W + FR_W;

  logic [LVL_W-1:0] fidx_full, cidx_full;
  logic [IDX_W-1:0] sf_ra, f_ra0, f_ra1, c_ra0, c_ra1;
  logic [ENT_W-1:0] sf_rd0, sf_rd1, f_rd0, f_rd1, c_rd0, c_rd1;
  logic [FS_W-1:0]  e0_d, e1_d, e0_q, e1_q;
  logic [FR_W-1:0]  fr_d, fr_q;
  logic             crs_d, crs_q;
  logic             unused_idx;

  assign fidx_full  = level >> FINE_SH;
  assign cidx_full  = level >> CRS_SH;
  assign sf_ra      = level[IDX_W-1:0];
  assign f_ra0      = fidx_full[IDX_W-1:0];
  assign f_ra1      = f_ra0 + 1'b1;
  assign c_ra0      = cidx_full[IDX_W-1:0];
  assign c_ra1      = c_ra0 + 1'b1;
  assign unused_idx = ^fidx_full[LVL_W-1:IDX_W] ^ ^cidx_full;

  gamma_lut #(.DEPTH(SF_N), .W(ENT_W), .IDX_W(IDX_W)) u_sf (
    .clk(clk), .we(we_sf), .waddr(waddr), .wdata(wval),
    .ra0(sf_ra), .ra1(sf_ra), .rd0(sf_rd0), .rd1(sf_rd1));
  gamma_lut #(.DEPTH(FINE_N), .W(ENT_W), .IDX_W(IDX_W)) u_fine (
    .clk(clk), .we(we_fine), .waddr(waddr), .wdata(wval),
    .ra0(f_ra0), .ra1(f_ra1), .rd0(f_rd0), .rd1(f_rd1));
  gamma_lut #(.DEPTH(CRS_N), .W(ENT_W), .IDX_W(IDX_W)) u_crs (
    .clk(clk), .we(we_crs), .waddr(waddr), .wdata(wval),
    .ra0(c_ra0), .ra1(c_ra1), .rd0(c_rd0), .rd1(c_rd1));

  // stage 0: segment choice and neighbour fetch
  always_comb begin
    if (int'(level) >= FULL) begin
      e0_d = fs; e1_d = fs; fr_d = '0; crs_d = 1'b1;
    end else if (int'(level) < SF_LIM) begin
      e0_d = FS_W'(sf_rd0); e1_d = FS_W'(sf_rd1); fr_d = '0; crs_d = 1'b0;
    end else if (int'(level) < FINE_LIM) begin
      e0_d = FS_W'(f_rd0); e1_d = FS_W'(f_rd1);
      fr_d = FR_W'(level[FINE_SH-1:0]); crs_d = 1'b0;
    end else begin
      e0_d = FS_W'(c_rd0); e1_d = FS_W'(c_rd1);
      fr_d = level[CRS_SH-1:0]; crs_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0_q <= '0; e1_q <= '0; fr_q <= '0; crs_q <= 1'b0;
    end else if (in_valid) begin
      e0_q <= e0_d; e1_q <= e1_d; fr_q <= fr_d; crs_q <= crs_d;
    end
  end

  // stage 1: interpolation, truncated toward zero
  logic signed [DIF_W-1:0] diff;
  logic        [DIF_W-1:0] mag;
  logic        [PR_W-1:0]  prod, shq;
  logic                    neg;
  logic        [FS_W-1:0]  res;
  logic                    unused_prod;

  assign diff = signed'({1'b0, e1_q}) - signed'({1'b0, e0_q});
  assign neg  = diff[DIF_W-1];
  assign mag  = neg ? DIF_W'(-diff) : DIF_W'(diff);
  assign prod = PR_W'(mag) * PR_W'(fr_q);
  assign shq  = crs_q ? (prod >> CRS_SH) : (prod >> FINE_SH);
  assign unused_prod = ^shq[PR_W-1:FS_W];
  assign res  = neg ? (e0_q - shq[FS_W-1:0]) : (e0_q + shq[FS_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out <= '0;
    else if (s1_valid) out <= res;
  end
endmodule

// File: rtl/gamma_mseg.sv
module gamma_mseg
  import gamma_pkg::*;
#(
  parameter int LVL_W   = 19,
  parameter int IDX_W   = 9,
  parameter int SF_N    = 9,
  parameter int FINE_N  = 257,
  parameter int CRS_N   = 257,
  parameter int FINE_SH = 3,
  parameter int CRS_SH  = 10,
  parameter int FS_W    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             pix_valid,
  input  logic [LVL_W-1:0] pix_r,
  input  logic [LVL_W-1:0] pix_g,
  input  logic [LVL_W-1:0] pix_b,
  output logic             out_valid,
  output logic [FS_W-1:0]  out_r,
  output logic [FS_W-1:0]  out_g,
  output logic [FS_W-1:0]  out_b
);
  logic                   prog_commit, prog_ainc, prog_phase;
  seg_e                   prog_seg;
  logic [IDX_W-1:0]       prog_idx;
  logic [2:0][ENT_W-1:0]  prog_val;
  logic [2:0][FS_W-1:0]   prog_fs;
  logic [2:0][LVL_W-1:0]  lvl;
  logic [2:0][FS_W-1:0]   res;
  logic                   v1_q, v2_q;

  gamma_prog #(.IDX_W(IDX_W), .SF_N(SF_N), .FINE_N(FINE_N), .CRS_N(CRS_N),
               .FS_W(FS_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .commit_o(prog_commit), .seg_o(prog_seg),
    .waddr_o(prog_idx), .ainc_o(prog_ainc), .phase_o(prog_phase),
    .wval_o(prog_val), .fs_o(prog_fs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= pix_valid;
      v2_q <= v1_q;
    end
  end

  assign lvl = {pix_b, pix_g, pix_r};

  for (genvar c = 0; c < 3; c++) begin : g_chan
    gamma_chan #(.LVL_W(LVL_W), .IDX_W(IDX_W), .SF_N(SF_N), .FINE_N(FINE_N),
                 .CRS_N(CRS_N), .FINE_SH(FINE_SH), .CRS_SH(CRS_SH),
                 .FS_W(FS_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .s1_valid(v1_q),
      .level(lvl[c]),
      .we_sf(prog_commit && (prog_seg == SEG_SF)),
      .we_fine(prog_commit && (prog_seg == SEG_FINE)),
      .we_crs(prog_commit && (prog_seg == SEG_CRS)),
      .waddr(prog_idx), .wval(prog_val[c]), .fs(prog_fs[c]), .out(res[c]));
  end

  assign out_valid = v2_q;
  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];
endmodule

// File: rtl/gamma_mseg_chk.sv
module gamma_mseg_chk
  import gamma_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int SF_N  = 9,
  parameter int FS_W  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic             pix_valid,
  input logic             out_valid,
  input logic [FS_W-1:0]  out_r,
  input logic [FS_W-1:0]  out_g,
  input logic [FS_W-1:0]  out_b,
  input logic             commit,
  input logic             phase,
  input logic             ainc,
  input seg_e             seg,
  input logic [IDX_W-1:0] idx
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> (out_valid == $past(pix_valid, 2)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_q == 2'd3) && !$past(pix_valid, 2)) |->
      ($stable(out_r) && $stable(out_g) && $stable(out_b)));

  p_commit_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (phase && cfg_we && (cfg_addr == A_DATA)));

  p_index_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == A_INDEX)) |=> !phase);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ainc && (seg == SEG_SF) && (idx == IDX_W'(SF_N - 1))) |=> (idx == '0));
endmodule

bind gamma_mseg gamma_mseg_chk #(.IDX_W(IDX_W), .SF_N(SF_N), .FS_W(FS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .pix_valid(pix_valid), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
  .out_b(out_b), .commit(prog_commit), .phase(prog_phase), .ainc(prog_ainc),
  .seg(prog_seg), .idx(prog_idx));

// File: tb/test_gamma_mseg.sv
module test_gamma_mseg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pix_valid;
  logic [18:0] pix_r, pix_g, pix_b;
  logic        out_valid;
  logic [16:0] out_r, out_g, out_b;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gamma_mseg i_gamma_mseg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid), .out_r(out_r),
    .out_g(out_g), .out_b(out_b));

  function automatic int tval(int seg, int i, int c);
    case (seg)
      0: return 100 + i * 50 + c * 10;
      1: return (c == 1) ? 30000 - i * 90 : 500 + i * 100 + c * 3;
      default: return (c == 1) ? 65000 - i * 250 : 1000 + i * 240 + c * 2;
    endcase
  endfunction

  function automatic int fsval(int c);
    case (c)
      0: return 65536;
      1: return 777;
      default: return 65535;
    endcase
  endfunction

  function automatic int lerp(int e0, int e1, int w, int sh);
    int d = e1 - e0;
    int m = (d < 0) ? -d : d;
    int q = (m * w) >> sh;
    return (d < 0) ? e0 - q : e0 + q;
  endfunction

  function automatic int expv(int c, int l);
    if (l >= 262144) return fsval(c);
    if (l < 8) return tval(0, l, c);
    if (l < 2048) return lerp(tval(1, l >> 3, c), tval(1, (l >> 3) + 1, c), l & 7, 3);
    return lerp(tval(2, l >> 10, c), tval(2, (l >> 10) + 1, c), l & 1023, 10);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic int hiw(int r, int g, int b);
    return ((r >> 6) << 20) | ((g >> 6) << 10) | (b >> 6);
  endfunction
  function automatic int low(int r, int g, int b);
    return ((r & 63) << 24) | ((g & 63) << 14) | (b & 63);
  endfunction

  task automatic put(int r, int g, int b);
    wr(1, hiw(r, g, b));
    wr(1, low(r, g, b));
  endtask

  task automatic set_idx(int seg, int i, int ai);
    wr(0, (ai << 15) | (seg << 9) | i);
  endtask

  // drive one pixel, results checked two edges later
  task automatic px(int r, int g, int b, int er, int eg, int eb, string req);
    @(negedge clk);
    pix_valid = 1'b1; pix_r = 19'(r); pix_g = 19'(g); pix_b = 19'(b);
    @(negedge clk);
    pix_valid = 1'b0;
    check("R8 early", int'(out_valid), 0);
    @(negedge clk);
    check("R8 valid", int'(out_valid), 1);
    check(req, int'(out_r), er);
    check(req, int'(out_g), eg);
    check(req, int'(out_b), eb);
  endtask

  task automatic pxe(int r, int g, int b, string req);
    px(r, g, b, expv(0, r), expv(1, g), expv(2, b), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int sv_r, sv_g, sv_b;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pix_valid = 1'b0; pix_r = '0; pix_g = '0; pix_b = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    check("R8 reset out", int'(out_r) + int'(out_g) + int'(out_b), 0);
    rst_n = 1'b1;

    // R7: load all tables through the index/data port with auto-increment
    for (int s = 0; s < 3; s++) begin
      set_idx(s, 0, 1);
      for (int i = 0; i < ((s == 0) ? 9 : 257); i++)
        put(tval(s, i, 0), tval(s, i, 1), tval(s, i, 2));
    end
    for (int c = 0; c < 3; c++) wr(2 + c, fsval(c));

    // R1, R2: superfine and fine range, all levels
    for (int l = 0; l < 2100; l++) pxe(l, l + 3, 2100 - l, "R1/R2 sweep");
    // R3: coarse range sweep including falling green curve
    for (int l = 2048; l < 262144; l += 97) pxe(l, l + 40, 262143 - (l - 2048), "R3 sweep");
    // R3 boundaries around entry 255/256, R4 full scale
    pxe(262143, 261120, 2048, "R3 top neighbour");
    pxe(262144, 524287, 300000, "R4 full scale");
    pxe(7, 8, 2047, "R1 segment edges");

    // R10: outputs hold with no pixel
    sv_r = int'(out_r); sv_g = int'(out_g); sv_b = int'(out_b);
    repeat (3) @(negedge clk);
    check("R10 hold r", int'(out_r), sv_r);
    check("R10 hold g", int'(out_g), sv_g);
    check("R10 hold b", int'(out_b), sv_b);
    check("R10 valid low", int'(out_valid), 0);

    // R6: wrap after superfine entry 8 lands next write at entry 0
    set_idx(0, 0, 1);
    for (int i = 0; i < 9; i++) put(tval(0, i, 0), tval(0, i, 1), tval(0, i, 2));
    put(11, 22, 33);
    px(0, 0, 0, 11, 22, 33, "R6 wrap to 0");
    pxe(1, 1, 1, "R6 entry 1 untouched");
    set_idx(0, 0, 0); put(tval(0, 0, 0), tval(0, 0, 1), tval(0, 0, 2));

    // R6: without auto-increment both writes go to entry 3
    set_idx(0, 3, 0);
    put(4000, 5000, 6000);
    put(7000, 8000, 9000);
    px(3, 4, 3, 7000, tval(0, 4, 1), 9000, "R6 no increment");
    set_idx(0, 3, 0); put(tval(0, 3, 0), tval(0, 3, 1), tval(0, 3, 2));

    // R5: entry commits only on the second word
    set_idx(0, 5, 0);
    wr(1, hiw(40000, 41000, 42000));
    pxe(5, 5, 5, "R5 half entry not committed");
    wr(1, low(40000, 41000, 42000));
    px(5, 5, 5, 40000, 41000, 42000, "R5 commit on second word");
    // R5: index write drops a pending upper half
    wr(1, hiw(1234, 1234, 1234));
    set_idx(0, 5, 0);
    put(2222, 3333, 4444);
    px(5, 5, 5, 2222, 3333, 4444, "R5 index clears pending");
    set_idx(0, 5, 0); put(tval(0, 5, 0), tval(0, 5, 1), tval(0, 5, 2));

    // R9: commit and read of the same entry in one cycle
    set_idx(0, 2, 0);
    wr(1, hiw(9000, 9100, 9200));
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'(low(9000, 9100, 9200));
    pix_valid = 1'b1; pix_r = 19'd2; pix_g = 19'd2; pix_b = 19'd2;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    check("R9 old r", int'(out_r), tval(0, 2, 0));
    check("R9 old g", int'(out_g), tval(0, 2, 1));
    check("R9 old b", int'(out_b), tval(0, 2, 2));
    px(2, 2, 2, 9000, 9100, 9200, "R9 new after");
    set_idx(0, 2, 0); put(tval(0, 2, 0), tval(0, 2, 1), tval(0, 2, 2));

    // R7: table code 3 discards entries
    set_idx(3, 0, 1);
    put(999, 999, 999);
    pxe(0, 0, 0, "R7 code 3 discarded");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule